// File: doc/BRIEF.md
# Predicated Last-Active Element Extractor

This block is one datapath stage of a scalable vector unit. It scans a governing predicate for the highest-numbered active element of a source vector. It then picks either that element or the element just after it, and produces a scalar result or a vector whose every lane holds the picked element. The operation is conditional. When no element is active, a vector destination is left alone and a scalar destination is rewritten as its own current value truncated to the element width.

The issuing logic presents the source vector, the predicate, the current destination contents, an element-size code, an after/last select and a scalar/vector mode flag, together with a one-cycle `in_valid` pulse. One cycle later the block presents the result with `out_valid` and a write enable. The vector length `VLEN` is a parameter: a multiple of 128 bits, at most 2048. The predicate has one bit per byte of the vector.

Control is a two-state machine. `ST_IDLE` means no result is presented. `ST_EMIT` means a result is presented in this cycle. Its transitions are:
- `IDLE->EMIT` on a pulse.
- `EMIT->EMIT` on a pulse in the cycle a result is out.
- `EMIT->IDLE` when no pulse arrives.

Top module: `lae_extract`

## Requirements
- R1: After reset and before any pulse, `out_valid`, `out_wen` and `out_data` are all zero.
- R2: An `in_valid` pulse produces exactly one `out_valid` cycle on the next clock. `out_valid` is low in any cycle that does not follow a pulse.
- R3: `esize` selects the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. The element count is VLEN divided by that width. Element i is active only when predicate bit i·(width/8) is set, which is the lowest bit of its byte group. Every other predicate bit has no effect.
- R4: With `sel_after` low, the picked element is the source element at the highest active index.
- R5: With `sel_after` high, the picked index is one past the highest active index. If that index equals the element count, it wraps to 0.
- R6: In vector mode (`vec_mode` high) with at least one active element, every element lane of `out_data` holds the picked element and `out_wen` is high.
- R7: In vector mode with no active element, `out_wen` is low and `out_data` equals the presented `dest_cur`.
- R8: In scalar mode with an active element, `out_wen` is high and `out_data` is the picked element, zero-extended. The result is 32 bits wide for 8-, 16- and 32-bit elements and 64 bits wide for 64-bit elements. All higher bits are zero.
- R9: In scalar mode with no active element, `out_wen` is high and `out_data` is the low element-width bits of `dest_cur`, zero-extended.
- R10: Pulses in consecutive cycles each yield their own correct result one cycle later, with `out_valid` held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request pulse |
| src_vec | input | VLEN | Source vector |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| dest_cur | input | VLEN | Current destination contents |
| esize | input | 2 | Element size code |
| sel_after | input | 1 | 1: element after last active, 0: last active |
| vec_mode | input | 1 | 1: broadcast to vector, 0: scalar result |
| out_valid | output | 1 | Result presented this cycle |
| out_wen | output | 1 | Destination must be written |
| out_data | output | VLEN | Result (scalar in low bits, zero above) |

## Verification
Several behaviours are checked by assertions on every cycle:
- The one-cycle pulse-to-result timing.
- The write enable always set for scalar results.
- The unchanged destination and cleared enable for a vector operation with no active element.
- The zero upper bits of narrow scalar results.
- The scanned index staying below the element count.
- Byte lanes matching in a byte broadcast.

Only the bench scenarios can show that the correct element is chosen. These scenarios cover the highest-index search across the four sizes, the wrap to element 0 in after mode, predicate bits ignored inside wider elements, the value of truncated scalar fallbacks and back-to-back operation.

// File: rtl/lae_pkg.sv
package lae_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } esize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

endpackage

// File: rtl/lae_scan.sv
// Finds the highest-numbered active element for the selected element size.
module lae_scan #(
    parameter int PRED_W = 32,
    parameter int IDX_W  = $clog2(PRED_W)
) (
    input  logic [PRED_W-1:0] pred,
    input  lae_pkg::esize_e   esize,
    output logic              found,
    output logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W:0]    n_elems
);
    int step_bytes;

    always_comb begin
        step_bytes = 1 << esize;
        found      = 1'b0;
        last_idx   = '0;
        for (int i = 0; i < PRED_W; i++) begin
            // only the lowest predicate bit of each element's byte group counts
            if (i * step_bytes < PRED_W) begin
                if (pred[IDX_W'((i * step_bytes) % PRED_W)]) begin
                    found    = 1'b1;
                    last_idx = IDX_W'(i);
                end
            end
        end
        n_elems = (IDX_W+1)'(PRED_W >> esize);
    end
endmodule

// File: rtl/lae_pick.sv
// Chooses the element index, extracts the element and forms the result.
module lae_pick #(
    parameter int VLEN   = 256,
    parameter int PRED_W = VLEN / 8,
    parameter int IDX_W  = $clog2(PRED_W)
) (
    input  logic [VLEN-1:0]  src_vec,
    input  logic [VLEN-1:0]  dest_cur,
    input  lae_pkg::esize_e  esize,
    input  logic             sel_after,
    input  logic             vec_mode,
    input  logic             found,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W:0]   n_elems,
    output logic [VLEN-1:0]  res_data,
    output logic             res_wen
);
    import lae_pkg::*;

    logic [IDX_W:0]      next_idx;
    logic [IDX_W-1:0]    sel_idx;
    logic [IDX_W-1:0]    byte_off;
    logic [VLEN-1:0]     shifted;
    logic [63:0]         width_mask;
    logic [63:0]         elem;
    logic [7:0][7:0]     elem_bytes;
    logic [2:0]          lane_mask;
    logic [VLEN-1:0]     bcast;
    logic [63:0]         scalar_val;

    // index selection with wrap for the after variant
    always_comb begin
        next_idx = {1'b0, last_idx} + 1'b1;
        if (sel_after) begin
            sel_idx = (next_idx >= n_elems) ? '0 : next_idx[IDX_W-1:0];
        end else begin
            sel_idx = last_idx;
        end
        byte_off = sel_idx << esize;
    end

    always_comb begin
        unique case (esize)
            SZ_BYTE: begin width_mask = 64'h0000_0000_0000_00FF; lane_mask = 3'd0; end
            SZ_HALF: begin width_mask = 64'h0000_0000_0000_FFFF; lane_mask = 3'd1; end
            SZ_WORD: begin width_mask = 64'h0000_0000_FFFF_FFFF; lane_mask = 3'd3; end
            SZ_DBL:  begin width_mask = 64'hFFFF_FFFF_FFFF_FFFF; lane_mask = 3'd7; end
            default: begin width_mask = '0;                      lane_mask = 3'd0; end
        endcase
    end

    always_comb begin
        shifted    = src_vec >> {byte_off, 3'b000};
        elem       = shifted[63:0] & width_mask;
        elem_bytes = elem;
        for (int j = 0; j < PRED_W; j++) begin
            bcast[8*j +: 8] = elem_bytes[3'(j) & lane_mask];
        end
    end

    always_comb begin
        scalar_val = found ? elem : (dest_cur[63:0] & width_mask);
        if (vec_mode) begin
            res_wen  = found;
            res_data = found ? bcast : dest_cur;
        end else begin
            res_wen  = 1'b1;
            res_data = VLEN'(scalar_val);
        end
    end
endmodule

// File: rtl/lae_extract.sv
module lae_extract #(
    parameter int VLEN = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VLEN-1:0]    src_vec,
    input  logic [VLEN/8-1:0]  pred,
    input  logic [VLEN-1:0]    dest_cur,
    input  logic [1:0]         esize,
    input  logic               sel_after,
    input  logic               vec_mode,
    output logic               out_valid,
    output logic               out_wen,
    output logic [VLEN-1:0]    out_data
);
    import lae_pkg::*;

    localparam int PRED_W = VLEN / 8;
    localparam int IDX_W  = $clog2(PRED_W);

    if ((VLEN % 128) != 0 || VLEN > 2048) begin : g_bad_vlen
        $error("lae_extract: VLEN must be a multiple of 128 and at most 2048");
    end

    esize_e           esize_t;
    logic             found;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W:0]   n_elems;
    logic [VLEN-1:0]  res_data;
    logic             res_wen;

    state_e           state_q, state_d;
    logic             wen_q;
    logic [VLEN-1:0]  data_q;

    assign esize_t = esize_e'(esize);

    lae_scan #(.PRED_W(PRED_W), .IDX_W(IDX_W)) u_scan (
        .pred     (pred),
        .esize    (esize_t),
        .found    (found),
        .last_idx (last_idx),
        .n_elems  (n_elems)
    );

    lae_pick #(.VLEN(VLEN), .PRED_W(PRED_W), .IDX_W(IDX_W)) u_pick (
        .src_vec   (src_vec),
        .dest_cur  (dest_cur),
        .esize     (esize_t),
        .sel_after (sel_after),
        .vec_mode  (vec_mode),
        .found     (found),
        .last_idx  (last_idx),
        .n_elems   (n_elems),
        .res_data  (res_data),
        .res_wen   (res_wen)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            data_q <= '0;
        end else if (in_valid) begin
            wen_q  <= res_wen;
            data_q <= res_data;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_wen   = out_valid && wen_q;
        out_data  = data_q;
    end

    p_pulse_to_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_pulse_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_index_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ({1'b0, last_idx} < n_elems));
    p_bcast_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode && found && esize == 2'd0)
        |=> (out_wen && out_data[7:0] == out_data[VLEN-1 -: 8]));
    p_keep_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode && !found)
        |=> (!out_wen && out_data == $past(dest_cur)));
    p_scalar_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode) |=> out_wen);
    p_scalar_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode && esize != 2'd3) |=> (out_data[VLEN-1:32] == '0));
endmodule

// File: tb/tb_lae_extract.sv
`timescale 1ns/1ps
module tb_lae_extract;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    typedef struct packed {
        logic [1:0]    es;
        logic          after;
        logic          vm;
        logic [PW-1:0] pr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TABLE [NV] = '{
        '{2'd0, 1'b0, 1'b1, 32'h0000_0110},   // byte, last=8
        '{2'd0, 1'b1, 1'b1, 32'h8000_0000},   // byte, after wraps to 0
        '{2'd1, 1'b0, 1'b0, 32'h0000_2000},   // half, odd bit ignored -> fallback
        '{2'd1, 1'b1, 1'b0, 32'h0000_1004},   // half, last=6 -> 7
        '{2'd2, 1'b0, 1'b1, 32'h0001_0000},   // word, last=4
        '{2'd2, 1'b1, 1'b1, 32'h1000_0000},   // word, last=7 wraps
        '{2'd3, 1'b0, 1'b0, 32'h0100_0001},   // dbl, last=3
        '{2'd3, 1'b1, 1'b0, 32'h0000_0100},   // dbl, last=1 -> 2
        '{2'd3, 1'b0, 1'b1, 32'hFEFE_FEFE},   // dbl, none active, keep
        '{2'd0, 1'b0, 1'b0, 32'h0000_0000},   // byte scalar fallback
        '{2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF},   // word, last=7
        '{2'd0, 1'b1, 1'b0, 32'h0000_0001}    // byte, last=0 -> 1
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [VLEN-1:0] src_vec, dest_cur;
    logic [PW-1:0]   pred = '0;
    logic [1:0]      esize = 2'd0;
    logic            sel_after = 1'b0;
    logic            vec_mode = 1'b0;
    logic            out_valid, out_wen;
    logic [VLEN-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lae_extract #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .pred(pred), .dest_cur(dest_cur), .esize(esize), .sel_after(sel_after),
        .vec_mode(vec_mode), .out_valid(out_valid), .out_wen(out_wen),
        .out_data(out_data)
    );

    task automatic check(input string tag, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference built from the requirements
    task automatic model(input vec_t v, output logic wen, output logic [VLEN-1:0] dat);
        int b, n, last, k;
        logic [63:0] m, e;
        logic [VLEN-1:0] sh;
        b = 1 << v.es;
        n = PW / b;
        last = -1;
        for (int i = 0; i < n; i++) if (v.pr[i*b]) last = i;
        m = (v.es == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*b)) - 64'd1);
        if (last < 0) begin
            wen = !v.vm;
            dat = v.vm ? dest_cur : VLEN'(dest_cur[63:0] & m);
        end else begin
            k = v.after ? ((last + 1 == n) ? 0 : last + 1) : last;
            sh = src_vec >> (k * b * 8);
            e = sh[63:0] & m;
            wen = 1'b1;
            if (v.vm) begin
                for (int j = 0; j < PW; j++) dat[8*j +: 8] = e[8*(j % b) +: 8];
            end else begin
                dat = VLEN'(e);
            end
        end
    endtask

    task automatic drive(input vec_t v);
        esize = v.es; sel_after = v.after; vec_mode = v.vm; pred = v.pr;
        in_valid = 1'b1;
    endtask

    task automatic check_result(input vec_t v, input string tag);
        logic ew;
        logic [VLEN-1:0] ed;
        model(v, ew, ed);
        check({tag, " valid"}, VLEN'(out_valid), VLEN'(1'b1));
        check({tag, " wen"},   VLEN'(out_wen),   VLEN'(ew));
        check({tag, " data"},  out_data,         ed);
    endtask

    initial begin
        for (int j = 0; j < PW; j++) begin
            src_vec[8*j +: 8]  = 8'(j * 13 + 5);
            dest_cur[8*j +: 8] = 8'hA0 ^ 8'(j);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", VLEN'(out_valid), '0);
        check("R1 wen",   VLEN'(out_wen),   '0);
        check("R1 data",  out_data,         '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", VLEN'(out_valid), '0);

        // table walk: R4/R5 pick, R6..R9 destination handling
        for (int t = 0; t < NV; t++) begin
            drive(TABLE[t]);
            @(negedge clk);
            in_valid = 1'b0;
            check_result(TABLE[t], {TABLE[t].after ? "R5" : "R4", "/",
                          TABLE[t].vm ? "R6_R7" : "R8_R9", " entry ", $sformatf("%0d", t)});
            @(negedge clk);
            check("R2 single cycle", VLEN'(out_valid), '0);
        end

        // R3: only the lowest bit of each half-word group counts
        drive('{2'd1, 1'b0, 1'b1, 32'hAAAA_AAAA});
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 odd bits ignored wen", VLEN'(out_wen), '0);
        check("R3 odd bits ignored data", out_data, dest_cur);

        // R7: vector fallback with a different destination value
        dest_cur = ~dest_cur;
        drive('{2'd0, 1'b1, 1'b1, 32'h0});
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 keep wen", VLEN'(out_wen), '0);
        check("R7 keep data", out_data, dest_cur);

        // R10: back-to-back pulses
        drive(TABLE[3]);
        @(negedge clk);
        check_result(TABLE[3], "R10 first");
        drive(TABLE[5]);
        @(negedge clk);
        check_result(TABLE[5], "R10 second");
        drive(TABLE[0]);
        @(negedge clk);
        in_valid = 1'b0;
        check_result(TABLE[0], "R10 third");
        @(negedge clk);
        check("R10 drops after burst", VLEN'(out_valid), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule